// File: doc/BRIEF.md
# Serial Split-Word Accumulator

This block is the arithmetic core of a bit-serial machine. It keeps a 24-bit two's-complement accumulator in a recirculating shift register. Once per word time it combines that accumulator with a memory operand that arrives one bit per clock, least significant bit first. The operation can add, subtract, load or shift. It works either on the whole word or on two independent 11-bit halves, and split operations take the same 24 clocks as full-word ones.

A word begins with a one-cycle strobe. The strobe marks the cycle in which operand bit 0 is presented, and the operation code is sampled in that cycle. The following 23 cycles carry bits 1 to 23. While a word runs, the serial accumulator output shows the previous accumulator value, one bit per cycle. A no-op word therefore reads the accumulator out. At the end of each word, the signs of the upper half and of the lower half of the result are latched for a conditional-branch test.

Top module: `split_serial_acc`

## Requirements
- R1: After reset the accumulator is zero, so `acc_bit` is 0, and both sign flags are 0.
- R2: A word runs for the cycle in which `word_start` is high and the 23 cycles after it. In cycle k of the word (k = 0..23), `acc_bit` shows bit k of the accumulator value held before the word. Between words, the accumulator holds its value and `acc_bit` shows its bit 0.
- R3: Code 4'b1101 replaces the accumulator with accumulator + operand, modulo 2^24.
- R4: Code 4'b1111 replaces the accumulator with accumulator − operand, modulo 2^24.
- R5: Code 4'b1100 adds the operand in split form. The upper half is bits 23..13 and the lower half is bits 11..1. Each half wraps modulo 2^11, no carry passes from one half to the other, and result bits 12 and 0 are zero.
- R6: Code 4'b1110 subtracts in split form, with the same halves, wrapping and zeroed bits 12 and 0 as R5.
- R7: Code 4'b1001 loads the operand into the accumulator.
- R8: Code 4'b0000 performs a one-place shift selected by `shift_sel`. Bit 2 of `shift_sel` selects right (1) or left (0). When `shift_sel[1:0]` = 00 the whole word shifts: a left shift fills bit 0 with 0, and a right shift is arithmetic and keeps bit 23.
- R9: With `shift_sel[1:0]` = 01, both halves shift independently. A left shift fills the lowest bit of each half with 0. A right shift keeps each half's top bit. Bits 12 and 0 become zero.
- R10: With `shift_sel[1:0]` = 10, only the upper half shifts; with 11, only the lower half shifts. The other half is unchanged, and bits 12 and 0 become zero.
- R11: Any other code leaves the accumulator unchanged.
- R12: From the cycle after bit 23, `neg_hi` equals bit 23 and `neg_lo` equals bit 11 of the new accumulator. Both stay unchanged until the next word ends.
- R13: A `word_start` pulse, or a change of `op_code` or `shift_sel`, during a running word does not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_start | input | 1 | Marks operand bit 0 and samples the operation |
| op_code | input | 4 | Operation code |
| shift_sel | input | 3 | Shift direction and scope for code 4'b0000 |
| opnd_bit | input | 1 | Serial operand bit, LSB first |
| acc_bit | output | 1 | Serial accumulator bit (pre-operation value during a word) |
| neg_hi | output | 1 | Sign of upper half / whole word of last result |
| neg_lo | output | 1 | Sign of lower half of last result |

## Verification
Every internal fault surfaces on `acc_bit` during the word that follows the damaged result, at most 24 to 48 cycles after the fault. A stale carry or a carry that crosses the half boundary shows as a wrong bit at position 1, 12 or 13 of the readback. A misaligned bit counter rotates the whole serial stream, and this shows in the readback of the next word. A wrong sign latch shows on the flags one cycle after bit 23, before the next word's first bit is sampled.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  typedef enum logic [1:0] {
    K_HOLD  = 2'd0,
    K_ADD   = 2'd1,
    K_LOAD  = 2'd2,
    K_SHIFT = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       split;
    logic       sub;
    logic       right;
    logic [1:0] scope;
  } ctl_t;

  localparam logic [3:0] OPC_ADD   = 4'b1101;
  localparam logic [3:0] OPC_SUB   = 4'b1111;
  localparam logic [3:0] OPC_SADD  = 4'b1100;
  localparam logic [3:0] OPC_SSUB  = 4'b1110;
  localparam logic [3:0] OPC_LOAD  = 4'b1001;
  localparam logic [3:0] OPC_SHIFT = 4'b0000;

  function automatic ctl_t decode(logic [3:0] opc, logic [2:0] sh);
    ctl_t c;
    c.kind  = K_HOLD;
    c.split = 1'b0;
    c.sub   = 1'b0;
    c.right = sh[2];
    c.scope = sh[1:0];
    case (opc)
      OPC_ADD:   c.kind = K_ADD;
      OPC_SUB:   begin c.kind = K_ADD; c.sub = 1'b1; end
      OPC_SADD:  begin c.kind = K_ADD; c.split = 1'b1; end
      OPC_SSUB:  begin c.kind = K_ADD; c.split = 1'b1; c.sub = 1'b1; end
      OPC_LOAD:  c.kind = K_LOAD;
      OPC_SHIFT: begin c.kind = K_SHIFT; c.split = (sh[1:0] != 2'b00); end
      default:   c.kind = K_HOLD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sacc_word_seq.sv
module sacc_word_seq
  import sacc_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_start,
  input  logic [3:0]       opc,
  input  logic [2:0]       sh,
  output logic             proc,
  output logic [IDX_W-1:0] bit_idx,
  output ctl_t             ctl
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  ctl_t             ctl_q, ctl_d;
  ctl_t             ctl_new;

  always_comb begin
    ctl_new  = decode(opc, sh);
    proc     = active_q | word_start;
    bit_idx  = active_q ? cnt_q : '0;
    ctl      = active_q ? ctl_q : ctl_new;
    active_d = active_q;
    cnt_d    = cnt_q;
    ctl_d    = ctl_q;
    if (proc) begin
      if (bit_idx == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        active_d = 1'b1;
        cnt_d    = bit_idx + IDX_W'(1);
      end
      if (!active_q) ctl_d = ctl_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ctl_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      ctl_q    <= ctl_d;
    end
  end

  // R13
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + IDX_W'(1)));

  // R13
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != LAST) |=> $stable(ctl_q));

  // R2
  word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == LAST) |=> !active_q);

endmodule

// File: rtl/sacc_serial_alu.sv
module sacc_serial_alu
  import sacc_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int HALF_W = 11,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc,
  input  logic [IDX_W-1:0] bit_idx,
  input  ctl_t             ctl,
  input  logic             a_cur,
  input  logic             a_next,
  input  logic             b,
  output logic             res
);

  localparam logic [IDX_W-1:0] LO_LSB = IDX_W'(1);
  localparam logic [IDX_W-1:0] LO_MSB = IDX_W'(HALF_W);
  localparam logic [IDX_W-1:0] GAP    = IDX_W'(HALF_W + 1);
  localparam logic [IDX_W-1:0] HI_LSB = IDX_W'(HALF_W + 2);
  localparam logic [IDX_W-1:0] HI_MSB = IDX_W'(WORD_W - 1);

  logic carry_q, carry_d;
  logic prev_q, prev_d;
  logic at_gap, in_hi, in_lo, half_start, half_end;
  logic cin, bx, sum, cout;
  logic full_l, full_r, half_l, half_r, half_sh;

  always_comb begin
    at_gap     = (bit_idx == '0) || (bit_idx == GAP);
    in_hi      = (bit_idx >= HI_LSB);
    in_lo      = (bit_idx >= LO_LSB) && (bit_idx <= LO_MSB);
    half_start = (bit_idx == LO_LSB) || (bit_idx == HI_LSB);
    half_end   = (bit_idx == LO_MSB) || (bit_idx == HI_MSB);

    cin  = ((bit_idx == '0) || (ctl.split && half_start)) ? ctl.sub : carry_q;
    bx   = b ^ ctl.sub;
    sum  = a_cur ^ bx ^ cin;
    cout = (a_cur & bx) | (a_cur & cin) | (bx & cin);

    full_l  = (bit_idx == '0) ? 1'b0 : prev_q;
    full_r  = (bit_idx == HI_MSB) ? a_cur : a_next;
    half_l  = half_start ? 1'b0 : prev_q;
    half_r  = half_end ? a_cur : a_next;
    half_sh = ctl.right ? half_r : half_l;

    case (ctl.kind)
      K_ADD:   res = sum;
      K_LOAD:  res = b;
      K_SHIFT: begin
        case (ctl.scope)
          2'b00:   res = ctl.right ? full_r : full_l;
          2'b01:   res = half_sh;
          2'b10:   res = in_hi ? half_sh : a_cur;
          default: res = in_lo ? half_sh : a_cur;
        endcase
      end
      default: res = a_cur;
    endcase
    if (ctl.split && at_gap) res = 1'b0;

    carry_d = carry_q;
    prev_d  = prev_q;
    if (proc) begin
      carry_d = cout;
      prev_d  = a_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      carry_q <= carry_d;
      prev_q  <= prev_d;
    end
  end

endmodule

// File: rtl/sacc_acc_sreg.sv
module sacc_acc_sreg #(
  parameter int WORD_W = 24,
  parameter int HALF_W = 11,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             split,
  input  logic             res,
  output logic             acc_cur,
  output logic             acc_next,
  output logic             neg_hi,
  output logic             neg_lo
);

  localparam int LO_MSB = HALF_W;
  localparam int GAP    = HALF_W + 1;
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LO_TOP = IDX_W'(HALF_W);

  logic [WORD_W-1:0] acc_q, acc_d;
  logic              lo_tmp_q, lo_tmp_d;
  logic              nhi_q, nhi_d, nlo_q, nlo_d;

  always_comb begin
    acc_d    = acc_q;
    lo_tmp_d = lo_tmp_q;
    nhi_d    = nhi_q;
    nlo_d    = nlo_q;
    if (proc) begin
      acc_d = {res, acc_q[WORD_W-1:1]};
      if (bit_idx == LO_TOP) lo_tmp_d = res;
      if (bit_idx == LAST) begin
        nhi_d = res;
        nlo_d = lo_tmp_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      lo_tmp_q <= 1'b0;
      nhi_q    <= 1'b0;
      nlo_q    <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      lo_tmp_q <= lo_tmp_d;
      nhi_q    <= nhi_d;
      nlo_q    <= nlo_d;
    end
  end

  assign acc_cur  = acc_q[0];
  assign acc_next = acc_q[1];
  assign neg_hi   = nhi_q;
  assign neg_lo   = nlo_q;

  // R12
  neg_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && bit_idx == LAST) |=> (neg_hi == acc_q[WORD_W-1]));

  // R12
  neg_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && bit_idx == LAST) |=> (neg_lo == acc_q[LO_MSB]));

  // R5
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && bit_idx == LAST && split) |=> (acc_q[0] == 1'b0 && acc_q[GAP] == 1'b0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proc |=> $stable(acc_q));

endmodule

// File: rtl/split_serial_acc.sv
module split_serial_acc #(
  parameter int WORD_W = 24,
  parameter int HALF_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_start,
  input  logic [3:0] op_code,
  input  logic [2:0] shift_sel,
  input  logic       opnd_bit,
  output logic       acc_bit,
  output logic       neg_hi,
  output logic       neg_lo
);

  import sacc_pkg::*;

  localparam int IDX_W = $clog2(WORD_W);

  logic             proc;
  logic [IDX_W-1:0] bit_idx;
  ctl_t             ctl;
  logic             a_cur, a_next, res;

  sacc_word_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_start (word_start),
    .opc        (op_code),
    .sh         (shift_sel),
    .proc       (proc),
    .bit_idx    (bit_idx),
    .ctl        (ctl)
  );

  sacc_serial_alu #(.WORD_W(WORD_W), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .proc    (proc),
    .bit_idx (bit_idx),
    .ctl     (ctl),
    .a_cur   (a_cur),
    .a_next  (a_next),
    .b       (opnd_bit),
    .res     (res)
  );

  sacc_acc_sreg #(.WORD_W(WORD_W), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .proc     (proc),
    .bit_idx  (bit_idx),
    .split    (ctl.split),
    .res      (res),
    .acc_cur  (a_cur),
    .acc_next (a_next),
    .neg_hi   (neg_hi),
    .neg_lo   (neg_lo)
  );

  assign acc_bit = a_cur;

endmodule

// File: tb/split_serial_acc_test.sv
`timescale 1ns/1ps
module split_serial_acc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_start = 1'b0;
  logic [3:0] op_code = 4'b0001;
  logic [2:0] shift_sel = 3'b000;
  logic       opnd_bit = 1'b0;
  logic       acc_bit, neg_hi, neg_lo;

  int          errors = 0;
  int          checks = 0;
  logic [23:0] m_acc = 24'h0;
  string       prev_tag = "R1";

  split_serial_acc uut (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .op_code(op_code),
    .shift_sel(shift_sel), .opnd_bit(opnd_bit), .acc_bit(acc_bit),
    .neg_hi(neg_hi), .neg_lo(neg_lo)
  );

  always #2 clk = ~clk;

  function automatic logic [23:0] model(logic [3:0] op, logic [2:0] sh,
                                        logic [23:0] a, logic [23:0] b);
    logic [10:0] ah = a[23:13];
    logic [10:0] al = a[11:1];
    logic [10:0] bh = b[23:13];
    logic [10:0] bl = b[11:1];
    logic [10:0] nh, nl;
    logic [23:0] r;
    nh = sh[2] ? {ah[10], ah[10:1]} : {ah[9:0], 1'b0};
    nl = sh[2] ? {al[10], al[10:1]} : {al[9:0], 1'b0};
    case (op)
      4'b1101: r = a + b;
      4'b1111: r = a - b;
      4'b1100: r = {11'(ah + bh), 1'b0, 11'(al + bl), 1'b0};
      4'b1110: r = {11'(ah - bh), 1'b0, 11'(al - bl), 1'b0};
      4'b1001: r = b;
      4'b0000: begin
        case (sh[1:0])
          2'b00:   r = sh[2] ? {a[23], a[23:1]} : {a[22:0], 1'b0};
          2'b01:   r = {nh, 1'b0, nl, 1'b0};
          2'b10:   r = {nh, 1'b0, al, 1'b0};
          default: r = {ah, 1'b0, nl, 1'b0};
        endcase
      end
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] op, logic [2:0] sh);
    case (op)
      4'b1101: return "R3";
      4'b1111: return "R4";
      4'b1100: return "R5";
      4'b1110: return "R6";
      4'b1001: return "R7";
      4'b0000: return (sh[1:0] == 2'b00) ? "R8" : ((sh[1:0] == 2'b01) ? "R9" : "R10");
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%06h expected=%06h", tag, what, act, exp);
    end
  endtask

  task automatic chk_flags(string tag);
    chk(tag, "sign flags", {22'h0, neg_hi, neg_lo}, {22'h0, m_acc[23], m_acc[11]});
  endtask

  task automatic do_word(logic [3:0] op, logic [2:0] sh, logic [23:0] opnd, bit inj);
    logic [23:0] got;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      got[k] = acc_bit;
      if (k == 0) chk_flags("R12");
      word_start = (k == 0) || (inj && k == 7);
      op_code    = (k == 0) ? op : 4'($urandom);
      shift_sel  = (k == 0) ? sh : 3'($urandom);
      opnd_bit   = opnd[k];
    end
    chk(prev_tag, "serial readback R2", got, m_acc);
    m_acc    = model(op, sh, m_acc, opnd);
    prev_tag = inj ? "R13" : tag_of(op, sh);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_start = 1'b0;
      op_code    = 4'($urandom);
      opnd_bit   = 1'($urandom);
      chk("R2", "idle acc_bit", {23'h0, acc_bit}, {23'h0, m_acc[0]});
      chk_flags("R12");
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs", {21'h0, acc_bit, neg_hi, neg_lo}, 24'h0);
    rst_n = 1'b1;
    idle(2);

    // directed corners
    do_word(4'b1001, 3'b000, 24'h7FFFFF, 1'b0);  // R7 load max positive
    do_word(4'b1101, 3'b000, 24'h000001, 1'b0);  // R3 overflow wrap
    do_word(4'b1111, 3'b000, 24'h000002, 1'b0);  // R4
    do_word(4'b1111, 3'b000, 24'h800000, 1'b0);  // R4 most negative
    do_word(4'b1001, 3'b000, {11'h3FF, 1'b1, 11'h7FF, 1'b1}, 1'b0);
    do_word(4'b1100, 3'b000, {11'h001, 1'b0, 11'h001, 1'b0}, 1'b0);  // R5 no cross carry
    do_word(4'b1110, 3'b000, {11'h401, 1'b0, 11'h001, 1'b0}, 1'b0);  // R6 borrow per half
    do_word(4'b1001, 3'b000, 24'h812345, 1'b0);
    do_word(4'b0000, 3'b100, 24'h0, 1'b0);       // R8 arithmetic right
    do_word(4'b0000, 3'b000, 24'h0, 1'b0);       // R8 left
    do_word(4'b0000, 3'b101, 24'h0, 1'b0);       // R9 right both halves
    do_word(4'b1001, 3'b000, 24'hFFFFFF, 1'b0);
    do_word(4'b0000, 3'b001, 24'h0, 1'b0);       // R9 left both halves
    do_word(4'b1001, 3'b000, 24'hA5A5A5, 1'b0);
    do_word(4'b0000, 3'b110, 24'h0, 1'b0);       // R10 upper half only
    do_word(4'b0000, 3'b011, 24'h0, 1'b0);       // R10 lower half only
    do_word(4'b0111, 3'b000, 24'hFFFFFF, 1'b0);  // R11 unused code
    do_word(4'b1101, 3'b000, 24'h123456, 1'b1);  // R13 stray start
    idle(3);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [3:0] op;
      int sel;
      sel = int'($urandom % 8);
      case (sel)
        0: op = 4'b1101;
        1: op = 4'b1111;
        2: op = 4'b1100;
        3: op = 4'b1110;
        4: op = 4'b1001;
        5, 6: op = 4'b0000;
        default: op = 4'($urandom);
      endcase
      do_word(op, 3'($urandom), 24'($urandom), ($urandom % 8) == 0);
      if (($urandom % 6) == 0) idle(1 + int'($urandom % 3));
    end

    do_word(4'b0001, 3'b000, 24'h0, 1'b0);  // R11 readback of last result
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule